// File: doc/BRIEF.md
# I2C Byte Buffer and Status Logic

This block sits between the register bus of an I2C peripheral and its bit-level shifter. It holds one transmit byte and one receive byte, and it reports their state through a status register. Software loads the transmit byte and reads the receive byte through a small address map. The shifter takes the transmit byte and delivers received bytes through single-cycle strobes. The block also raises DMA trigger requests and two interrupt flags, and it offers a self-clearing flush of both buffers.

Each holding buffer is a two-state machine. The states are `HB_EMPTY` and `HB_FULL`. The transmit buffer takes these transitions:
- `HB_EMPTY`→`HB_FULL` on a software write.
- `HB_FULL`→`HB_FULL` on a software write that coincides with a shifter take.
- `HB_FULL`→`HB_EMPTY` on a shifter take alone, or on a flush.

The receive buffer takes these transitions:
- `HB_EMPTY`→`HB_FULL` on a shifter load.
- `HB_FULL`→`HB_EMPTY` on a software read, or on a flush.
- `HB_FULL`→`HB_FULL` when a load arrives with no read. The arriving byte is dropped.

Software misuse sets one of two sticky error flags: writing a full transmit buffer, or reading an empty receive buffer. While either flag is set, the block asks the protocol engine to answer with a NACK.

Top module: `i2c_bytebuf`

## Requirements
- R1: After reset, status reads 0x20, `nack_req`, both interrupt outputs and `dma_rx_req` are 0, and `dma_tx_req` is 1.
- R2: A bus write to address 0 while the transmit buffer is empty stores the byte. Status bit 5 reads 0, `shf_tx_valid` is 1 and `shf_tx_byte` equals the written byte from the next cycle on.
- R3: A shifter take while the transmit buffer is full empties it on the next cycle. A bus write to address 0 in the same cycle wins: it stores the new byte, the buffer stays full, and no error is flagged.
- R4: A bus write to address 0 while the transmit buffer is full, with no take in that cycle, keeps the held byte and sets status bit 7. Bit 7 stays set until a status write with bit 7 equal to 0.
- R5: A shifter load while the receive buffer is empty stores the byte and sets status bit 0. A bus read of address 0x1 returns the stored byte. A read while the buffer is full empties it on the next cycle.
- R6: A bus read of address 1 while the receive buffer is empty sets status bit 3. Bit 3 stays set until a status write with bit 3 equal to 0.
- R7: A shifter load while the receive buffer is full drops the new byte, keeps the stored byte, and raises `rx_overflow` in that same cycle.
- R8: `nack_req` is 1 whenever status bit 7 or bit 3 is set.
- R9: A status write with bit 2 set flushes the block on the next cycle. The transmit buffer goes empty, the receive buffer goes empty, and both interrupt flags clear. Status bit 2 always reads 0.
- R10: `dma_tx_req` equals the transmit-empty state and `dma_rx_req` equals the receive-full state.
- R11: The transmit interrupt flag sets when the shifter takes the byte. It clears on a write to address 0 or on a flush. The receive interrupt flag sets when a load fills the empty buffer. It clears on a read of a full buffer or on a flush. `tx_irq` and `rx_irq` are the flags ANDed with `tx_ie` and `rx_ie`.
- R12: Addresses are 0 for transmit data (reads 0), 1 for receive data, 2 for status, and 3 reads 0. Status bits 6, 4, 2 and 1 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| shf_tx_valid | output | 1 | Transmit byte available to the shifter |
| shf_tx_byte | output | 8 | Transmit byte |
| shf_tx_take | input | 1 | Shifter accepts the transmit byte |
| shf_rx_load | input | 1 | Shifter delivers a received byte |
| shf_rx_byte | input | 8 | Received byte |
| rx_overflow | output | 1 | Received byte dropped this cycle |
| nack_req | output | 1 | NACK request to the protocol engine |
| dma_tx_req | output | 1 | DMA trigger: transmit buffer empty |
| dma_rx_req | output | 1 | DMA trigger: receive buffer full |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_irq | output | 1 | Masked transmit interrupt flag |
| rx_irq | output | 1 | Masked receive interrupt flag |

## Verification
The hardest case to reach from the ports is a software write that lands in the same cycle as a shifter take of a full buffer, because a take only matters in the cycles when the buffer is already full. Loads that arrive exactly while the receive buffer is full are hard to reach for the same reason. Directed sequences first fill each buffer and then fire the colliding strobes. After that, thousands of random cycles raise the take and load strobes on about half the cycles, so that these collisions and their interaction with flushes recur often.

// File: rtl/i2c_bytebuf_pkg.sv
package i2c_bytebuf_pkg;
    localparam int ADDR_W   = 2;
    localparam int DATA_W   = 8;

    localparam logic [ADDR_W-1:0] A_TXDATA = 2'd0;
    localparam logic [ADDR_W-1:0] A_RXDATA = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;

    localparam int ST_TXERR  = 7;
    localparam int ST_TXEMP  = 5;
    localparam int ST_RXERR  = 3;
    localparam int ST_FLUSH  = 2;
    localparam int ST_RXFULL = 0;

    typedef enum logic {
        HB_EMPTY = 1'b0,
        HB_FULL  = 1'b1
    } hold_state_t;
endpackage

// File: rtl/i2c_bytebuf_txhold.sv
module i2c_bytebuf_txhold
    import i2c_bytebuf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         take,
    input  logic         flush,
    output logic         empty,
    output logic [W-1:0] hold,
    output logic         werr_set,
    output logic         irq_flag
);
    hold_state_t state_q, state_d;
    logic [W-1:0] hold_q;
    logic         irq_q;
    logic         store;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HB_EMPTY: if (!flush && wr) state_d = HB_FULL;
            HB_FULL: begin
                if (flush)      state_d = HB_EMPTY;
                else if (wr)    state_d = HB_FULL;
                else if (take)  state_d = HB_EMPTY;
            end
            default: state_d = HB_EMPTY;
        endcase
    end

    always_comb begin
        store    = !flush && wr && ((state_q == HB_EMPTY) || take);
        werr_set = wr && (state_q == HB_FULL) && !take;
        empty    = (state_q == HB_EMPTY);
        hold     = hold_q;
        irq_flag = irq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (store) hold_q <= wdata;
            if (flush || wr)                        irq_q <= 1'b0;
            else if (take && state_q == HB_FULL)    irq_q <= 1'b1;
        end
    end

    assert_take_empties_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HB_FULL && take && !wr && !flush) |=> empty);
    assert_write_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HB_FULL && take && wr && !flush) |=> (!empty && hold_q == $past(wdata)));
    assert_full_keeps_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (werr_set && !flush) |=> ($stable(hold_q) && !empty));
    assert_flush_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !irq_q));
endmodule

// File: rtl/i2c_bytebuf_rxhold.sv
module i2c_bytebuf_rxhold
    import i2c_bytebuf_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] ldata,
    input  logic         rd,
    input  logic         flush,
    output logic         full,
    output logic [W-1:0] hold,
    output logic         rerr_set,
    output logic         overflow,
    output logic         irq_flag
);
    hold_state_t state_q, state_d;
    logic [W-1:0] hold_q;
    logic         irq_q;
    logic         capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HB_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HB_EMPTY: if (!flush && load) state_d = HB_FULL;
            HB_FULL:  if (flush || rd)    state_d = HB_EMPTY;
            default:  state_d = HB_EMPTY;
        endcase
    end

    always_comb begin
        capture  = !flush && load && (state_q == HB_EMPTY);
        rerr_set = rd && (state_q == HB_EMPTY);
        overflow = load && (state_q == HB_FULL);
        full     = (state_q == HB_FULL);
        hold     = hold_q;
        irq_flag = irq_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (capture) hold_q <= ldata;
            if (flush)                         irq_q <= 1'b0;
            else if (capture)                  irq_q <= 1'b1;
            else if (rd && state_q == HB_FULL) irq_q <= 1'b0;
        end
    end

    assert_drop_keeps_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !rd && !flush) |=> (full && $stable(hold_q)));
    assert_read_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && rd) |=> !full);
    assert_flush_rx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!full && !irq_q));
endmodule

// File: rtl/i2c_bytebuf_errflags.sv
module i2c_bytebuf_errflags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_tx,
    input  logic set_rx,
    input  logic clr_tx,
    input  logic clr_rx,
    output logic tx_err,
    output logic rx_err,
    output logic nack
);
    logic tx_q, rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= 1'b0;
            rx_q <= 1'b0;
        end else begin
            if (set_tx)      tx_q <= 1'b1;
            else if (clr_tx) tx_q <= 1'b0;
            if (set_rx)      rx_q <= 1'b1;
            else if (clr_rx) rx_q <= 1'b0;
        end
    end

    always_comb begin
        tx_err = tx_q;
        rx_err = rx_q;
        nack   = tx_q | rx_q;
    end

    assert_txerr_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q && !clr_tx) |=> tx_q);
    assert_rxerr_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_q && !clr_rx) |=> rx_q);
    assert_err_nacks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_tx || set_rx) |=> nack);
endmodule

// File: rtl/i2c_bytebuf.sv
module i2c_bytebuf
    import i2c_bytebuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              shf_tx_valid,
    output logic [DATA_W-1:0] shf_tx_byte,
    input  logic              shf_tx_take,
    input  logic              shf_rx_load,
    input  logic [DATA_W-1:0] shf_rx_byte,
    output logic              rx_overflow,
    output logic              nack_req,
    output logic              dma_tx_req,
    output logic              dma_rx_req,
    input  logic              tx_ie,
    input  logic              rx_ie,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic wr_tx, rd_rx, wr_st, flush;
    logic clr_txerr, clr_rxerr;
    logic tx_empty, rx_full, werr_set, rerr_set;
    logic tx_err, rx_err, tx_flag, rx_flag;
    logic [DATA_W-1:0] tx_hold, rx_hold, status;

    always_comb begin
        wr_tx     = bus_wr && (bus_addr == A_TXDATA);
        rd_rx     = bus_rd && (bus_addr == A_RXDATA);
        wr_st     = bus_wr && (bus_addr == A_STATUS);
        flush     = wr_st && bus_wdata[ST_FLUSH];
        clr_txerr = wr_st && !bus_wdata[ST_TXERR];
        clr_rxerr = wr_st && !bus_wdata[ST_RXERR];
    end

    i2c_bytebuf_txhold #(.W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr(wr_tx), .wdata(bus_wdata),
        .take(shf_tx_take), .flush(flush), .empty(tx_empty),
        .hold(tx_hold), .werr_set(werr_set), .irq_flag(tx_flag)
    );

    i2c_bytebuf_rxhold #(.W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .load(shf_rx_load), .ldata(shf_rx_byte),
        .rd(rd_rx), .flush(flush), .full(rx_full), .hold(rx_hold),
        .rerr_set(rerr_set), .overflow(rx_overflow), .irq_flag(rx_flag)
    );

    i2c_bytebuf_errflags u_err (
        .clk(clk), .rst_n(rst_n), .set_tx(werr_set), .set_rx(rerr_set),
        .clr_tx(clr_txerr), .clr_rx(clr_rxerr),
        .tx_err(tx_err), .rx_err(rx_err), .nack(nack_req)
    );

    always_comb begin
        status            = '0;
        status[ST_TXERR]  = tx_err;
        status[ST_TXEMP]  = tx_empty;
        status[ST_RXERR]  = rx_err;
        status[ST_RXFULL] = rx_full;
        unique case (bus_addr)
            A_RXDATA: bus_rdata = rx_hold;
            A_STATUS: bus_rdata = status;
            default:  bus_rdata = '0;
        endcase
        shf_tx_valid = !tx_empty;
        shf_tx_byte  = tx_hold;
        dma_tx_req   = tx_empty;
        dma_rx_req   = rx_full;
        tx_irq       = tx_flag & tx_ie;
        rx_irq       = rx_flag & rx_ie;
    end

    assert_flush_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STATUS) |-> !bus_rdata[ST_FLUSH]);
    assert_dma_rx_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (shf_rx_load && !dma_rx_req && !flush) |=> dma_rx_req);
endmodule

// File: tb/i2c_bytebuf_test.sv
`timescale 1ns/100ps
module i2c_bytebuf_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       shf_tx_valid, shf_tx_take = 1'b0, shf_rx_load = 1'b0;
    logic [7:0] shf_tx_byte, shf_rx_byte = '0;
    logic       rx_overflow, nack_req, dma_tx_req, dma_rx_req;
    logic       tx_ie = 1'b1, rx_ie = 1'b1, tx_irq, rx_irq;

    int tests = 0, fails = 0;
    bit done = 0;

    // bench model
    bit m_txe = 1, m_rxf = 0, m_txwe = 0, m_rxre = 0, m_txf = 0, m_rxfl = 0;
    logic [7:0] m_txb = 0, m_rxb = 0;

    always #2.5 clk = ~clk;

    i2c_bytebuf uut (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_status();
        return {m_txwe, 1'b0, m_txe, 1'b0, m_rxre, 3'b000} | {7'd0, m_rxf};
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [1:0] a);
        case (a)
            2'd1:    return m_rxb;
            2'd2:    return exp_status();
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_state();
        chk("R12", "status", (bus_addr == 2) ? bus_rdata : exp_status(), exp_status());
        chk("R8",  "nack_req", nack_req, m_txwe | m_rxre);
        chk("R10", "dma_tx_req", dma_tx_req, m_txe);
        chk("R10", "dma_rx_req", dma_rx_req, m_rxf);
        chk("R11", "tx_irq", tx_irq, m_txf & tx_ie);
        chk("R11", "rx_irq", rx_irq, m_rxfl & rx_ie);
        chk("R2",  "shf_tx_valid", shf_tx_valid, !m_txe);
        if (!m_txe) chk("R2", "shf_tx_byte", shf_tx_byte, m_txb);
    endtask

    // one clock: drive at negedge, check combinational, then model the edge
    task automatic cycle(input bit wr, input bit rd, input logic [1:0] a,
                         input logic [7:0] wd, input bit take, input bit load,
                         input logic [7:0] ld);
        bit wtx, rrx, wst, fl;
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
        shf_tx_take = take; shf_rx_load = load; shf_rx_byte = ld;
        #1;
        chk("R12", "bus_rdata", bus_rdata, exp_rdata(a));
        chk("R7",  "rx_overflow", rx_overflow, load & m_rxf);
        @(posedge clk);
        wtx = wr && a == 0; rrx = rd && a == 1; wst = wr && a == 2;
        fl = wst && wd[2];
        // transmit side
        if (fl) begin m_txe = 1; m_txf = 0; end
        else if (wtx) begin
            if (m_txe || take) begin m_txb = wd; m_txe = 0; end
            else m_txwe = 1;
            m_txf = 0;
        end else if (take && !m_txe) begin m_txe = 1; m_txf = 1; end
        // receive side
        if (fl) begin m_rxf = 0; m_rxfl = 0; end
        else if (m_rxf) begin
            if (rrx) begin m_rxf = 0; m_rxfl = 0; end
        end else begin
            if (rrx) m_rxre = 1;
            if (load) begin m_rxb = ld; m_rxf = 1; m_rxfl = 1; end
        end
        if (wst && !wd[7]) m_txwe = 0;
        if (wst && !wd[3]) m_rxre = 0;
        #1;
        check_state();
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset values
        bus_addr = 2; #1;
        chk("R1", "reset status", bus_rdata, 8'h20);
        chk("R1", "reset nack", nack_req, 0);
        chk("R1", "reset dma_tx", dma_tx_req, 1);
        chk("R1", "reset dma_rx", dma_rx_req, 0);
        chk("R1", "reset irqs", {tx_irq, rx_irq}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 write empty, R4 write full, R3 take with write
        cycle(1, 0, 0, 8'hA5, 0, 0, 0);
        chk("R2", "tx byte", shf_tx_byte, 8'hA5);
        cycle(1, 0, 0, 8'h3C, 0, 0, 0);
        chk("R4", "held byte kept", shf_tx_byte, 8'hA5);
        chk("R4", "txwe set", nack_req, 1);
        cycle(0, 0, 2, 0, 1, 0, 0);
        cycle(1, 0, 0, 8'h11, 0, 0, 0);
        cycle(1, 0, 0, 8'h77, 1, 0, 0);
        chk("R3", "write wins take", shf_tx_byte, 8'h77);
        cycle(0, 0, 2, 0, 1, 0, 0);
        chk("R3", "take empties", dma_tx_req, 1);
        cycle(1, 0, 2, 8'h88, 0, 0, 0);
        chk("R4", "txwe holds on bit7=1", nack_req, 1);
        cycle(1, 0, 2, 8'h08, 0, 0, 0);
        chk("R4", "txwe cleared", nack_req, 0);

        // R6 read empty, R5 load, R7 overflow
        cycle(0, 1, 1, 0, 0, 0, 0);
        chk("R6", "rxre set", nack_req, 1);
        cycle(0, 0, 1, 0, 0, 1, 8'h5A);
        cycle(0, 0, 1, 0, 0, 1, 8'hC3);
        chk("R7", "stored byte kept", bus_rdata, 8'h5A);
        cycle(0, 1, 1, 0, 0, 0, 0);
        cycle(1, 0, 2, 8'h00, 0, 0, 0);
        chk("R6", "rxre cleared", nack_req, 0);

        // R9 flush with both buffers full and irq flags set
        cycle(0, 0, 2, 0, 0, 1, 8'h42);
        cycle(1, 0, 0, 8'h24, 0, 0, 0);
        cycle(1, 0, 2, 8'h04, 0, 0, 0);
        chk("R9", "flush status", bus_rdata, 8'h20);

        // random mix
        for (int i = 0; i < 6000; i++) begin
            int op = $urandom_range(0, 5);
            logic [7:0] wd = 8'($urandom);
            if (op == 3) wd[2] = ($urandom_range(0, 7) == 0);
            tx_ie = ($urandom_range(0, 3) != 0);
            rx_ie = ($urandom_range(0, 3) != 0);
            case (op)
                1: cycle(1, 0, 0, wd, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 8'($urandom));
                2: cycle(0, 1, 1, 0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 8'($urandom));
                3: cycle(1, 0, 2, wd, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 8'($urandom));
                default: cycle(0, 0, 2'($urandom_range(0, 3)), 0, $urandom_range(0, 1) == 1,
                               $urandom_range(0, 1) == 1, 8'($urandom));
            endcase
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule